// File: doc/BRIEF.md
# Stalled-Packet Deadlock Recovery Initiator

This controller sits beside one router input buffer that holds a single virtual channel. It counts how many consecutive cycles the head packet has sat in the buffer without leaving. When that count reaches a programmable limit, it assumes the packet may be trapped in a cyclic buffer dependency and starts a recovery. It sends a probe along the dependency and measures how long the probe takes to come back. A returned probe confirms the cycle. The controller then sends a move message that names an absolute network cycle, counts down to that cycle, and asserts a one-cycle spin strobe. The strobe pushes the stalled packet one hop forward, and every other packet in the same loop moves at the same time.

After each spin the controller sends a probe_move message. If it comes back, the deadlock is still there, and a new spin is already scheduled at the cycle the message carried. If it does not come back, the controller drops the attempt. Any router can run one of these controllers, and no central arbiter is involved. The controller works only on the special messages and the strobe. It leaves routing and the crossbar untouched.

States: `ST_IDLE` (watch the buffer), `ST_PROBE` (send probe), `ST_WAIT_PROBE` (time the round trip), `ST_MOVE` (send move), `ST_WAIT_MOVE` (count down and wait for the move to return), `ST_ARMED` (move is back, count down), `ST_SPIN` (strobe), `ST_PMOVE` (send probe_move), `ST_WAIT_PMOVE` (count down and wait for the probe_move to return). Transitions:
- `ST_IDLE`→`ST_PROBE` when the stall limit is reached.
- `ST_PROBE`→`ST_WAIT_PROBE`.
- `ST_WAIT_PROBE`→`ST_MOVE` when the probe returns.
- `ST_MOVE`→`ST_WAIT_MOVE`.
- `ST_WAIT_MOVE`→`ST_ARMED` when the move returns, or →`ST_SPIN` when it returns in the final countdown cycle.
- `ST_ARMED`→`ST_SPIN` when the countdown ends.
- `ST_SPIN`→`ST_PMOVE`.
- `ST_PMOVE`→`ST_WAIT_PMOVE`.
- `ST_WAIT_PMOVE`→`ST_ARMED` or `ST_SPIN`, on the same rules as `ST_WAIT_MOVE`.
- Abort: any waiting or sending state returns to `ST_IDLE` when the packet departs, when the buffer empties, on probe timeout, or when a countdown ends before its message has returned.

Top module: `spin_initiator`

## Requirements
- R1: While the buffer is occupied and nothing departs, a probe (msg_kind 1) is sent in the cycle after the cfg_threshold-th consecutive stalled cycle, and not earlier.
- R2: A departure or an empty buffer clears the stall count, so the next probe needs cfg_threshold fresh stalled cycles.
- R3: A probe return (rx_kind 1) seen k cycles after the probe was sent produces a move (msg_kind 2) in the next cycle. Its msg_spin_cycle equals the current cycle number plus k plus MARGIN.
- R4: If no probe returns within PROBE_WAIT cycles, no move is sent, the controller goes idle, and the stall count restarts from zero.
- R5: When the move has returned (rx_kind 2) by the end of the countdown, spin_strobe is high for exactly one cycle, in the cycle whose number equals the announced spin cycle.
- R6: If the move has not returned by the last countdown cycle, no strobe is given and the controller rearms the stall count.
- R7: The cycle after a spin, a probe_move (msg_kind 3) is sent with the spin cycle set to the current cycle plus the last round trip plus MARGIN. If it returns (rx_kind 3), another strobe fires at that cycle.
- R8: A probe_move that does not return ends recovery without a strobe, and the stall count restarts.
- R9: A departure or an empty buffer during any waiting state cancels the recovery with no strobe.
- R10: Received messages are ignored while idle and whenever their kind is not the one being awaited.
- R11: After reset no message and no strobe are output. A message and a strobe never occur in the same cycle, and a probe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also zeroes the network cycle count |
| buf_occupied | input | 1 | Input buffer holds a head packet |
| buf_depart | input | 1 | Head packet leaves this cycle |
| cfg_threshold | input | CNT_W | Stalled cycles before a probe |
| rx_valid | input | 1 | A returned special message addressed to this controller |
| rx_kind | input | 2 | Kind of returned message: 1 probe, 2 move, 3 probe_move |
| msg_valid | output | 1 | Special message to send this cycle |
| msg_kind | output | 2 | Kind of sent message: 1 probe, 2 move, 3 probe_move |
| msg_spin_cycle | output | TIME_W | Absolute spin cycle carried by a move or probe_move, zero otherwise |
| spin_strobe | output | 1 | One-cycle push of the stalled packet |

## Verification
The assertions take for granted three things about the inputs. rx_valid marks only messages that this controller started. A departure pulse implies that the buffer was occupied. cfg_threshold does not change during a run. The stimulus holds cfg_threshold at 5 and raises buf_depart only with buf_occupied high. It returns each message once, a chosen number of cycles after it was sent, and always well inside the probe wait and the countdown window, except in the cases built to test expiry. The countdown-expiry cases then hold the return back on purpose.

// File: rtl/spin_init_pkg.sv
package spin_init_pkg;
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_PROBE = 2'd1,
        K_MOVE  = 2'd2,
        K_PMOVE = 2'd3
    } msg_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_WAIT_PROBE,
        ST_MOVE,
        ST_WAIT_MOVE,
        ST_ARMED,
        ST_SPIN,
        ST_PMOVE,
        ST_WAIT_PMOVE
    } rec_state_e;
endpackage

// File: rtl/stall_timer.sv
module stall_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             occupied,
    input  logic             depart,
    input  logic [CNT_W-1:0] threshold,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   next_cnt;
    logic             stalled;

    assign stalled  = enable && occupied && !depart;
    assign next_cnt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign expired  = stalled && (next_cnt >= {1'b0, threshold});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!stalled || expired) begin
            cnt <= '0;
        end else begin
            cnt <= next_cnt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/rtt_meter.sv
module rtt_meter #(
    parameter int PROBE_WAIT = 32,
    localparam int RW = $clog2(PROBE_WAIT) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          active,
    input  logic          capture,
    output logic [RW-1:0] rtt,
    output logic          expired
);
    logic [RW-1:0] cnt;

    assign expired = active && (cnt == RW'(PROBE_WAIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            rtt <= '0;
        end else begin
            if (start) begin
                cnt <= '0;
            end else if (active) begin
                cnt <= cnt + RW'(1);
            end
            if (capture) begin
                rtt <= cnt + RW'(1);
            end
        end
    end
endmodule

// File: rtl/spin_countdown.sv
module spin_countdown #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [DW-1:0] cnt;

    assign last = (cnt == DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - DW'(1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - DW'(1);
        end
    end
endmodule

// File: rtl/spin_initiator.sv
module spin_initiator
    import spin_init_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PROBE_WAIT = 32,
    parameter int MARGIN     = 4,
    parameter int TIME_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_occupied,
    input  logic              buf_depart,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic              rx_valid,
    input  logic [1:0]        rx_kind,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [TIME_W-1:0] msg_spin_cycle,
    output logic              spin_strobe
);
    localparam int RW = $clog2(PROBE_WAIT) + 1;

    rec_state_e        state, state_nx;
    logic [TIME_W-1:0] now;
    logic [RW-1:0]     rtt;
    logic [TIME_W-1:0] delay;
    logic              stall_hit, probe_late, cd_last, gone;
    logic              rx_probe, rx_move, rx_pmove;

    assign gone     = !buf_occupied || buf_depart;
    assign rx_probe = rx_valid && (rx_kind == K_PROBE);
    assign rx_move  = rx_valid && (rx_kind == K_MOVE);
    assign rx_pmove = rx_valid && (rx_kind == K_PMOVE);
    assign delay    = TIME_W'(rtt) + TIME_W'(MARGIN);

    stall_timer #(.CNT_W(CNT_W)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state == ST_IDLE),
        .occupied  (buf_occupied),
        .depart    (buf_depart),
        .threshold (cfg_threshold),
        .expired   (stall_hit)
    );

    rtt_meter #(.PROBE_WAIT(PROBE_WAIT)) u_rtt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (state == ST_PROBE),
        .active  (state == ST_WAIT_PROBE),
        .capture (state == ST_WAIT_PROBE && rx_probe),
        .rtt     (rtt),
        .expired (probe_late)
    );

    spin_countdown #(.DW(TIME_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_MOVE || state == ST_PMOVE),
        .load_val (delay),
        .run      (state == ST_WAIT_MOVE || state == ST_ARMED || state == ST_WAIT_PMOVE),
        .last     (cd_last)
    );

    // network cycle number, common to all routers reset together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now <= '0;
        end else begin
            now <= now + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (stall_hit) state_nx = ST_PROBE;
            end
            ST_PROBE: begin
                state_nx = gone ? ST_IDLE : ST_WAIT_PROBE;
            end
            ST_WAIT_PROBE: begin
                if (gone)           state_nx = ST_IDLE;
                else if (rx_probe)  state_nx = ST_MOVE;
                else if (probe_late) state_nx = ST_IDLE;
            end
            ST_MOVE: begin
                state_nx = gone ? ST_IDLE : ST_WAIT_MOVE;
            end
            ST_WAIT_MOVE: begin
                if (gone)         state_nx = ST_IDLE;
                else if (cd_last) state_nx = rx_move ? ST_SPIN : ST_IDLE;
                else if (rx_move) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (gone)         state_nx = ST_IDLE;
                else if (cd_last) state_nx = ST_SPIN;
            end
            ST_SPIN: begin
                state_nx = ST_PMOVE;
            end
            ST_PMOVE: begin
                state_nx = gone ? ST_IDLE : ST_WAIT_PMOVE;
            end
            ST_WAIT_PMOVE: begin
                if (gone)          state_nx = ST_IDLE;
                else if (cd_last)  state_nx = rx_pmove ? ST_SPIN : ST_IDLE;
                else if (rx_pmove) state_nx = ST_ARMED;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        msg_valid      = 1'b0;
        msg_kind       = K_NONE;
        msg_spin_cycle = '0;
        spin_strobe    = 1'b0;
        unique case (state)
            ST_PROBE: begin
                msg_valid = 1'b1;
                msg_kind  = K_PROBE;
            end
            ST_MOVE: begin
                msg_valid      = 1'b1;
                msg_kind       = K_MOVE;
                msg_spin_cycle = now + delay;
            end
            ST_PMOVE: begin
                msg_valid      = 1'b1;
                msg_kind       = K_PMOVE;
                msg_spin_cycle = now + delay;
            end
            ST_SPIN: spin_strobe = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/spin_initiator_chk.sv
module spin_initiator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       buf_occupied,
    input logic       buf_depart,
    input logic       rx_valid,
    input logic [1:0] rx_kind,
    input logic       msg_valid,
    input logic [1:0] msg_kind,
    input logic       spin_strobe
);
    a_r11_msg_or_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(spin_strobe && msg_valid));

    a_r11_probe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd1) |=> !msg_valid);

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        spin_strobe |=> !spin_strobe);

    a_r7_pmove_after_spin: assert property (@(posedge clk) disable iff (!rst_n)
        spin_strobe |=> (msg_valid && msg_kind == 2'd3));

    a_r1_probe_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd1) |-> $past(buf_occupied && !buf_depart));

    a_r3_move_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2) |-> $past(rx_valid && rx_kind == 2'd1));

    a_r9_spin_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        spin_strobe |-> $past(buf_occupied && !buf_depart));
endmodule

bind spin_initiator spin_initiator_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_occupied (buf_occupied),
    .buf_depart   (buf_depart),
    .rx_valid     (rx_valid),
    .rx_kind      (rx_kind),
    .msg_valid    (msg_valid),
    .msg_kind     (msg_kind),
    .spin_strobe  (spin_strobe)
);

// File: tb/tb_spin_initiator.sv
module tb_spin_initiator;
    localparam int CNT_W  = 8;
    localparam int PW     = 32;
    localparam int MARGIN = 4;
    localparam int TIME_W = 16;
    localparam int THR    = 5;

    typedef struct {
        int    kind;   // 0 strobe, 1 probe, 2 move, 3 probe_move
        int    cycle;
        int    spin;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_occupied = 1'b0;
    logic buf_depart = 1'b0;
    logic [CNT_W-1:0] cfg_threshold = CNT_W'(THR);
    logic rx_valid = 1'b0;
    logic [1:0] rx_kind = 2'd0;
    logic msg_valid;
    logic [1:0] msg_kind;
    logic [TIME_W-1:0] msg_spin_cycle;
    logic spin_strobe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int obs_cnt = 0;
    bit done = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    spin_initiator #(.CNT_W(CNT_W), .PROBE_WAIT(PW), .MARGIN(MARGIN), .TIME_W(TIME_W)) dut (
        .clk(clk), .rst_n(rst_n), .buf_occupied(buf_occupied), .buf_depart(buf_depart),
        .cfg_threshold(cfg_threshold), .rx_valid(rx_valid), .rx_kind(rx_kind),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_spin_cycle(msg_spin_cycle),
        .spin_strobe(spin_strobe)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_item(input int kind, input int cycle, input int spin, input string tag);
        item_t it;
        it.kind = kind; it.cycle = cycle; it.spin = spin; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic goto(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_rx(input int c, input logic [1:0] k);
        goto(c);
        rx_valid = 1'b1; rx_kind = k;
        goto(c + 1);
        rx_valid = 1'b0; rx_kind = 2'd0;
    endtask

    // monitor: pops expected items as outputs appear
    always @(negedge clk) begin
        if (rst_n && !done && (msg_valid || spin_strobe)) begin
            int k;
            obs_cnt++;
            k = spin_strobe ? 0 : int'(msg_kind);
            if (msg_valid && spin_strobe) chk(1'b0, "R11 message with strobe", 1, 0);
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected output kind", k, -1);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(k == it.kind, {it.tag, " kind"}, k, it.kind);
                chk(cyc == it.cycle, {it.tag, " cycle"}, cyc, it.cycle);
                if (it.kind >= 2)
                    chk(int'(msg_spin_cycle) == it.spin, {it.tag, " spin cycle"},
                        int'(msg_spin_cycle), it.spin);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int p, s, d, s2, p3, s3, d3, p4, s4, d4, p5;
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R11 reset msg_valid", int'(msg_valid), 0);
        chk(spin_strobe == 1'b0, "R11 reset spin_strobe", int'(spin_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: returns while idle are ignored
        goto(2);
        rx_valid = 1'b1; rx_kind = 2'd1;
        goto(4); rx_kind = 2'd2;
        goto(6); rx_valid = 1'b0; rx_kind = 2'd0;
        goto(9);
        chk(obs_cnt == 0, "R10 idle rx produced output", obs_cnt, 0);

        // R1/R2: stall, departure clears count
        goto(10); buf_occupied = 1'b1;
        goto(13); buf_depart = 1'b1;
        goto(14); buf_depart = 1'b0;
        p = 14 + THR;
        expect_item(1, p, 0, "R2 probe after cleared count");
        // R4: no return, timeout then rearm
        p = p + PW + 1 + THR;
        expect_item(1, p, 0, "R4 probe after timeout rearm");

        // R3/R5/R7: probe returns after 3 cycles
        pulse_rx(p + 3, 2'd1);
        s = p + 4; d = 3 + MARGIN;
        expect_item(2, s, s + d, "R3 move");
        pulse_rx(s + 1, 2'd1);       // R10 wrong kind during move wait
        pulse_rx(s + 2, 2'd2);
        expect_item(0, s + d, 0, "R5 spin strobe");
        expect_item(3, s + d + 1, s + 2 * d + 1, "R7 probe_move");
        pulse_rx(s + d + 3, 2'd3);
        expect_item(0, s + 2 * d + 1, 0, "R7 second strobe");
        s2 = s + 2 * d + 2;
        expect_item(3, s2, s2 + d, "R7 probe_move after second spin");
        // R8: no return
        p3 = s2 + d + THR;
        expect_item(1, p3, 0, "R8 probe after probe_move loss");

        // R6: move never returns
        pulse_rx(p3 + 2, 2'd1);
        s3 = p3 + 3; d3 = 2 + MARGIN;
        expect_item(2, s3, s3 + d3, "R6 move");
        p4 = s3 + d3 + THR;
        expect_item(1, p4, 0, "R6 probe after move loss");

        // R9: buffer empties while armed
        pulse_rx(p4 + 4, 2'd1);
        s4 = p4 + 5; d4 = 4 + MARGIN;
        expect_item(2, s4, s4 + d4, "R9 move");
        pulse_rx(s4 + 2, 2'd2);
        goto(s4 + 4); buf_occupied = 1'b0;
        goto(s4 + 6); buf_occupied = 1'b1;
        p5 = s4 + 6 + THR;
        expect_item(1, p5, 0, "R9 probe after cancel");
        goto(p5); buf_occupied = 1'b0;
        goto(p5 + 20);
        chk(q.size() == 0, "R9 missing expected outputs", q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule